// File: doc/BRIEF.md
# Row-Column Group Test Defect Locator

This block turns the outcome of two sets of group self-tests into a defect map for a two-dimensional array of interchangeable units. The first set groups the units by row and the second by column, so every unit sits in exactly one group of each set. A passing group clears all of its members. A failing group only says that some member may be bad. The block loads one fail vector for the rows and one for the columns, each through its own valid/ready handshake. Both vectors arrive whole, in parallel, so loading time does not depend on the number of units.

A compute pulse builds the suspect map. A unit is marked when both its row group and its column group failed. If at most one group failed in each set, the isolation is exact. If more failed, the marking is conservative, and some good units are marked on purpose. If only one of the two sets reports any failure, the results contradict each other. In that case the block raises an error flag and marks nothing. After computing, the block sweeps the array and presents the coordinates of each suspect unit, one per strobe. It then pulses a completion signal.

Top module: `grid_defect_locator`

## Requirements
- R1: After reset, `suspectMap`, `exact`, `conservative`, `inconsistent`, `suspectValid` and `done` are all 0, and both `rowReady` and `colReady` are 1.
- R2: A fail vector is captured on a rising edge where its valid and ready are both high. Ready is high only while the block is idle. A later capture replaces the earlier vector.
- R3: `computeReq` is ignored unless the block is idle, both vectors have been captured since reset, and neither valid is high in the same cycle. An ignored request produces no sweep and leaves the flags unchanged.
- R4: When the results are consistent, bit r*COLS+c of `suspectMap` equals `rowFail[r] & colFail[c]` for the captured vectors, where bit 0 of each vector is row 0 or column 0. The map is valid from the cycle after the accepted request.
- R5: `exact` is 1 when each captured vector has at most one bit set. Otherwise it is 0.
- R6: `conservative` is 1 when either captured vector has two or more bits set. It is always the complement of `exact` after a compute.
- R7: When exactly one of the two vectors is all zero and the other is not, `inconsistent` is 1, `suspectMap` is all zero and no suspect is reported.
- R8: The sweep runs for ROWS*COLS cycles, starting the cycle after the accepted request. It visits units in row-major order, and `suspectValid` is high with `suspectRow`/`suspectCol` for each marked unit. `done` is then high for exactly one cycle.
- R9: During the sweep and the `done` cycle, both readies are low. Valids and `computeReq` have no effect, and the captured vectors are unchanged.
- R10: The map and all three flags hold their values until the next accepted compute or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowValid | input | 1 | Row fail vector is offered |
| rowReady | output | 1 | Row vector can be taken |
| rowFail | input | ROWS | One fail bit per row group |
| colValid | input | 1 | Column fail vector is offered |
| colReady | output | 1 | Column vector can be taken |
| colFail | input | COLS | One fail bit per column group |
| computeReq | input | 1 | Request to build the suspect map and sweep it |
| suspectMap | output | ROWS*COLS | Suspect bitmap, bit r*COLS+c |
| exact | output | 1 | Isolation is exact |
| conservative | output | 1 | Isolation over-marks |
| inconsistent | output | 1 | Only one grouping reported failures |
| suspectValid | output | 1 | Coordinates below name a suspect unit |
| suspectRow | output | RW | Row of the reported unit |
| suspectCol | output | CW | Column of the reported unit |
| done | output | 1 | One-cycle end of sweep |

## Verification
The hardest situation to reach is traffic that arrives while a sweep is running. The block has to refuse that traffic and keep its captured vectors intact, and from the ports this shows up only indirectly. The stimulus holds a different row vector valid and keeps `computeReq` high for the whole sweep. It then checks that the sweep length is still ROWS*COLS and that the readies stay low. A second compute, issued with no reload, must give back the same map. The contradictory case, where only one grouping fails, is driven from both sides, including once with two column failures. This shows that `inconsistent` and `conservative` can both be set.

// File: rtl/gdl_pkg.sv
package gdl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } gdl_state_t;

  typedef struct packed {
    logic loadRow;
    logic loadCol;
    logic capture;
    logic scanning;
  } gdl_ctrl_t;
endpackage

// File: rtl/gdl_ctrl.sv
module gdl_ctrl
  import gdl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rowValid,
  input  logic      colValid,
  input  logic      computeReq,
  input  logic      lastIdx,
  output logic      rowReady,
  output logic      colReady,
  output logic      done,
  output gdl_ctrl_t ctrl
);
  gdl_state_t state, stateNext;
  logic rowLoaded, colLoaded;
  logic inIdle;

  assign inIdle   = (state == ST_IDLE);
  assign rowReady = inIdle;
  assign colReady = inIdle;
  assign done     = (state == ST_DONE);

  always_comb begin
    ctrl.loadRow  = inIdle && rowValid;
    ctrl.loadCol  = inIdle && colValid;
    ctrl.capture  = inIdle && computeReq && rowLoaded && colLoaded
                    && !rowValid && !colValid;
    ctrl.scanning = (state == ST_SCAN);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (ctrl.capture) stateNext = ST_SCAN;
      ST_SCAN: if (lastIdx) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rowLoaded <= 1'b0;
      colLoaded <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.loadRow) rowLoaded <= 1'b1;
      if (ctrl.loadCol) colLoaded <= 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R8
  AST_DONE_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rstN) $rose(done) |-> $past(ctrl.scanning && lastIdx)); // R8
endmodule

// File: rtl/gdl_datapath.sv
module gdl_datapath
  import gdl_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int N  = ROWS * COLS,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  gdl_ctrl_t       ctrl,
  input  logic [ROWS-1:0] rowFail,
  input  logic [COLS-1:0] colFail,
  output logic [N-1:0]    suspectMap,
  output logic            exact,
  output logic            conservative,
  output logic            inconsistent,
  output logic            lastIdx,
  output logic            suspectValid,
  output logic [RW-1:0]   suspectRow,
  output logic [CW-1:0]   suspectCol
);
  logic [ROWS-1:0] rowVec;
  logic [COLS-1:0] colVec;
  logic [N-1:0]    crossMap;
  logic [IW-1:0]   idx;
  logic rowSparse, colSparse, rowAny, colAny, mismatch;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign crossMap[r*COLS + c] = rowVec[r] & colVec[c];
    end
  end

  assign rowSparse = ((rowVec & (rowVec - 1'b1)) == '0);
  assign colSparse = ((colVec & (colVec - 1'b1)) == '0);
  assign rowAny    = |rowVec;
  assign colAny    = |colVec;
  assign mismatch  = rowAny ^ colAny;

  assign lastIdx      = (idx == IW'(N - 1));
  assign suspectValid = ctrl.scanning && suspectMap[idx];
  assign suspectRow   = RW'(32'(idx) / COLS);
  assign suspectCol   = CW'(32'(idx) % COLS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowVec       <= '0;
      colVec       <= '0;
      suspectMap   <= '0;
      exact        <= 1'b0;
      conservative <= 1'b0;
      inconsistent <= 1'b0;
      idx          <= '0;
    end else begin
      if (ctrl.loadRow) rowVec <= rowFail;
      if (ctrl.loadCol) colVec <= colFail;
      if (ctrl.capture) begin
        suspectMap   <= mismatch ? '0 : crossMap;
        exact        <= rowSparse && colSparse;
        conservative <= !(rowSparse && colSparse);
        inconsistent <= mismatch;
        idx          <= '0;
      end else if (ctrl.scanning && !lastIdx) begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_INCON_EMPTY: assert property (@(posedge clk) disable iff (!rstN) inconsistent |-> (suspectMap == '0)); // R7
  AST_EXACT_SPARSE: assert property (@(posedge clk) disable iff (!rstN) exact |-> ($countones(suspectMap) <= 1)); // R5
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rstN) ctrl.scanning |=> ($stable(rowVec) && $stable(colVec))); // R9
  AST_SUSPECT_CROSS: assert property (@(posedge clk) disable iff (!rstN) suspectValid |-> (rowVec[suspectRow] && colVec[suspectCol])); // R4
endmodule

// File: rtl/grid_defect_locator.sv
module grid_defect_locator
  import gdl_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int N  = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rowValid,
  output logic            rowReady,
  input  logic [ROWS-1:0] rowFail,
  input  logic            colValid,
  output logic            colReady,
  input  logic [COLS-1:0] colFail,
  input  logic            computeReq,
  output logic [N-1:0]    suspectMap,
  output logic            exact,
  output logic            conservative,
  output logic            inconsistent,
  output logic            suspectValid,
  output logic [RW-1:0]   suspectRow,
  output logic [CW-1:0]   suspectCol,
  output logic            done
);
  gdl_ctrl_t ctrl;
  logic      lastIdx;

  gdl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rowValid(rowValid), .colValid(colValid),
    .computeReq(computeReq), .lastIdx(lastIdx), .rowReady(rowReady),
    .colReady(colReady), .done(done), .ctrl(ctrl)
  );

  gdl_datapath #(.ROWS(ROWS), .COLS(COLS)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rowFail(rowFail), .colFail(colFail),
    .suspectMap(suspectMap), .exact(exact), .conservative(conservative),
    .inconsistent(inconsistent), .lastIdx(lastIdx), .suspectValid(suspectValid),
    .suspectRow(suspectRow), .suspectCol(suspectCol)
  );
endmodule

// File: tb/grid_defect_locator_tb_top.sv
module grid_defect_locator_tb_top;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int N = ROWS * COLS;

  typedef struct packed {
    logic [3:0] rowV;
    logic [3:0] colV;
    logic       expExact;
    logic       expIncon;
  } vec_t;

  localparam vec_t TABLE [7] = '{
    '{4'b0100, 4'b0010, 1'b1, 1'b0},
    '{4'b0000, 4'b0000, 1'b1, 1'b0},
    '{4'b1010, 4'b0110, 1'b0, 1'b0},
    '{4'b0001, 4'b0000, 1'b1, 1'b1},
    '{4'b0000, 4'b1100, 1'b0, 1'b1},
    '{4'b1111, 4'b1111, 1'b0, 1'b0},
    '{4'b1000, 4'b0001, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowValid = 1'b0, colValid = 1'b0, computeReq = 1'b0;
  logic [ROWS-1:0] rowFail = '0;
  logic [COLS-1:0] colFail = '0;
  logic rowReady, colReady, exact, conservative, inconsistent, suspectValid, done;
  logic [N-1:0] suspectMap;
  logic [1:0] suspectRow, suspectCol;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  grid_defect_locator #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rstN(rstN), .rowValid(rowValid), .rowReady(rowReady), .rowFail(rowFail),
    .colValid(colValid), .colReady(colReady), .colFail(colFail), .computeReq(computeReq),
    .suspectMap(suspectMap), .exact(exact), .conservative(conservative),
    .inconsistent(inconsistent), .suspectValid(suspectValid), .suspectRow(suspectRow),
    .suspectCol(suspectCol), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadRow(input logic [ROWS-1:0] v);
    @(negedge clk); rowValid = 1'b1; rowFail = v;
    @(negedge clk); rowValid = 1'b0;
  endtask

  task automatic loadCol(input logic [COLS-1:0] v);
    @(negedge clk); colValid = 1'b1; colFail = v;
    @(negedge clk); colValid = 1'b0;
  endtask

  function automatic logic [N-1:0] expMap(input logic [3:0] r, input logic [3:0] c);
    logic [N-1:0] m = '0;
    if ((r != 0) != (c != 0)) return '0;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++)
        m[i*COLS + j] = r[i] & c[j];
    return m;
  endfunction

  // Pulse compute and follow the sweep; inject drives traffic during it (R9)
  task automatic runCompute(input logic [3:0] r, input logic [3:0] c, input bit inject, input string tag);
    logic [N-1:0] em = expMap(r, c);
    int seen = 0;
    int cyc = 0;
    bit orderOk = 1;
    bit readyOk = 1;
    int expCount = $countones(em);
    int k = 0;
    @(negedge clk); computeReq = 1'b1;
    @(negedge clk); computeReq = 1'b0;
    if (inject) begin rowValid = 1'b1; rowFail = ~r; computeReq = 1'b1; end
    while (!done && cyc < 40) begin
      if (inject && (rowReady || colReady)) readyOk = 0;
      if (suspectValid) begin
        while (k < N && !em[k]) k++;
        if (k >= N || int'(suspectRow) != k / COLS || int'(suspectCol) != k % COLS) orderOk = 0;
        k++;
        seen++;
      end
      cyc++;
      @(negedge clk);
    end
    if (inject && (rowReady || colReady)) readyOk = 0;
    rowValid = 1'b0; computeReq = 1'b0;
    check(suspectMap == em, {"R4 map ", tag}, suspectMap, em);
    check(exact == ((r & (r - 1)) == 0 && (c & (c - 1)) == 0), {"R5 exact ", tag}, exact, !exact);
    check(conservative == !exact, {"R6 conservative ", tag}, conservative, !exact);
    check(inconsistent == ((r != 0) != (c != 0)), {"R7 inconsistent ", tag}, inconsistent, (r != 0) != (c != 0));
    check(seen == expCount && orderOk, {"R8 suspects ", tag}, seen, expCount);
    check(cyc == N, {"R8 sweep length ", tag}, cyc, N);
    if (inject) check(readyOk, {"R9 ready low in sweep ", tag}, readyOk, 1);
    @(negedge clk);
    check(!done && rowReady, {"R8 done single ", tag}, done, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(suspectMap == 0 && !exact && !conservative && !inconsistent, "R1 outputs", suspectMap, 0);
    check(!suspectValid && !done && rowReady && colReady, "R1 handshake", {rowReady, colReady}, 2'b11);
    rstN = 1'b1;
    // R3 compute ignored with only row loaded
    loadRow(4'b0010);
    @(negedge clk); computeReq = 1'b1;
    @(negedge clk); computeReq = 1'b0;
    begin
      bit sawDone = 0;
      for (int i = 0; i < 24; i++) begin @(negedge clk); if (done || suspectValid) sawDone = 1; end
      check(!sawDone && !exact && !conservative, "R3 ignored before both loads", sawDone, 0);
    end
    // Table walk
    for (int t = 0; t < 7; t++) begin
      loadRow(TABLE[t].rowV);
      loadCol(TABLE[t].colV);
      runCompute(TABLE[t].rowV, TABLE[t].colV, 0, $sformatf("t%0d", t));
      check(exact == TABLE[t].expExact && inconsistent == TABLE[t].expIncon,
            $sformatf("R5 R7 table %0d", t), {exact, inconsistent}, {TABLE[t].expExact, TABLE[t].expIncon});
    end
    // R10 hold after sweep
    repeat (5) @(negedge clk);
    check(suspectMap == expMap(4'b1000, 4'b0001) && exact, "R10 hold", suspectMap, expMap(4'b1000, 4'b0001));
    // R2 overwrite
    loadRow(4'b0001);
    loadRow(4'b0100);
    loadCol(4'b1000);
    runCompute(4'b0100, 4'b1000, 0, "R2 overwrite");
    // R9 traffic during sweep, then rerun without reload
    runCompute(4'b0100, 4'b1000, 1, "R9 inject");
    runCompute(4'b0100, 4'b1000, 0, "R9 vectors kept");
    // R3 compute in same cycle as load ignored
    @(negedge clk); colValid = 1'b1; colFail = 4'b0011; computeReq = 1'b1;
    @(negedge clk); colValid = 1'b0; computeReq = 1'b0;
    @(negedge clk);
    check(rowReady && !suspectValid && suspectMap == expMap(4'b0100, 4'b1000), "R3 ignored with load", suspectMap, expMap(4'b0100, 4'b1000));
    runCompute(4'b0100, 4'b0011, 0, "R2 col only reload");
    // R1 reset after use
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(suspectMap == 0 && !exact && !conservative && !inconsistent && !done, "R1 reset after use", suspectMap, 0);
    rstN = 1'b1;
    @(negedge clk); computeReq = 1'b1;
    @(negedge clk); computeReq = 1'b0;
    repeat (20) @(negedge clk);
    check(!exact && !conservative && rowReady, "R3 loads cleared by reset", exact, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule